// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides who owns the system bus for each transfer slot: the CPU, DMA channel 0 or DMA channel 1. A channel starts when its request line is raised while it is idle. At that moment the arbiter captures a unit count and a mode bit for the channel. Burst mode keeps the bus for consecutive units. Cycle-steal mode takes one unit at a time. The bus reports the end of every slot with a one-cycle strobe. The arbiter decrements the count of the channel that owned the slot and picks the owner of the next slot.

Two priority schemes are available. Fixed priority favours channel 0. Round-robin hands priority to the channel that was not served last. Under fixed priority, a cycle-steal channel 0 facing a burst channel 1 interleaves with it. The burst channel then fills the slot that would otherwise go back to the CPU. Round-robin does not allow a burst channel and a cycle-steal channel to be active together. A start request that would create such a mix is refused and reported on an error pulse.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, the owner is the CPU (owner code 0), both remaining counts are zero and `cfg_err` is low.
- R2: Exactly one bit of `gnt` is high at all times. `gnt[0]` is the CPU, `gnt[1]` is channel 0 and `gnt[2]` is channel 1. `owner` encodes the same choice as 0 (CPU), 1 (channel 0) or 2 (channel 1).
- R3: The owner changes only at the clock edge where `xfer_done` is high. With `xfer_done` low, the owner holds whatever requests arrive.
- R4: A request on an idle channel (remaining count zero) with a nonzero length loads that length and latches its mode (`ch_burst` 1 = burst, 0 = cycle-steal). Each completed slot owned by the channel decrements its count by one. A request on a channel whose count is nonzero is ignored.
- R5: When no channel has units left after a slot ends, the next slot goes to the CPU.
- R6: Under fixed priority with both channels in burst mode, channel 0 takes the next slot even if channel 1 is mid-burst. Channel 1 resumes only after channel 0's count reaches zero.
- R7: Under fixed priority, with channel 0 in cycle-steal mode and channel 1 in burst mode, slots alternate between channel 0 and channel 1 with none for the CPU until both are done.
- R8: A cycle-steal channel with no active burst channel beside it yields one slot to the CPU after each unit.
- R9: A lone burst channel keeps every slot until its count reaches zero.
- R10: Under round-robin (`prio_rr` = 1), the channel just granted becomes lowest priority. Two burst channels therefore alternate slot by slot, and channel 0 is favoured first after reset.
- R11: Under round-robin, a start request whose mode differs from the other active channel's mode is refused. If both channels start in the same cycle with different modes, channel 1 is refused. The refused count stays zero and `cfg_err` is high for one cycle after the refused request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | 2 | Start request per channel |
| ch_burst | input | 2 | Mode per channel, 1 = burst, 0 = cycle-steal |
| ch0_len | input | CNT_W | Unit count captured at channel 0 start |
| ch1_len | input | CNT_W | Unit count captured at channel 1 start |
| prio_rr | input | 1 | 1 = round-robin, 0 = fixed priority |
| xfer_done | input | 1 | End of the current slot |
| gnt | output | 3 | One-hot grant {ch1, ch0, cpu} |
| owner | output | 2 | Encoded current owner |
| cfg_err | output | 1 | Refused mixed-mode start under round-robin |
| ch0_left | output | CNT_W | Units remaining on channel 0 |
| ch1_left | output | CNT_W | Units remaining on channel 1 |

## Verification
The bench replays slot sequences whose owners it works out by hand:
- **Channel 0 preempting a running channel 1 burst.** A design that finished the running burst first would show extra channel-1 slots where channel-0 slots are expected.
- **The cycle-steal/burst interleave.** An arbiter that returned the bus to the CPU between steal units would insert CPU slots into an alternation that should contain none.
- **Round-robin alternation and refusal of a mixed-mode start.** A missed refusal shows up as a nonzero count on the rejected channel.

It also holds `xfer_done` low with requests waiting, to catch a grant that moves off a slot boundary. It re-requests a busy channel to confirm that its count is not reloaded.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic [1:0] {
      OWN_CPU = 2'd0,
      OWN_CH0 = 2'd1,
      OWN_CH1 = 2'd2
   } own_e;
endpackage

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   input  logic             mode_burst,
   input  logic             dec,
   output logic [CNT_W-1:0] remain,
   output logic             burst_q,
   output logic             active,
   output logic             nxt_active,
   output logic             nxt_burst
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign active     = (remain != '0);
   assign nxt_active = load | (active & ~(dec & (remain == ONE)));
   assign nxt_burst  = load ? mode_burst : burst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain  <= '0;
         burst_q <= 1'b0;
      end else if (load) begin
         remain  <= len;
         burst_q <= mode_burst;
      end else if (dec) begin
         remain  <= remain - ONE;
      end
   end

   AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> (remain == $past(remain) - ONE)); // R4
   AST_DEC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> active); // R4
endmodule

// File: rtl/dma_slot_pick.sv
module dma_slot_pick
   import dma_arb_pkg::*;
(
   input  logic [1:0] act,
   input  logic [1:0] brst,
   input  logic       rr_mode,
   input  logic       rr_pri,
   input  own_e       cur,
   output own_e       nxt
);
   logic       hi, cand, cur_steal;
   logic [1:0] burst_act;

   always_comb begin
      hi        = rr_mode ? rr_pri : 1'b0;
      cand      = act[hi] ? hi : ~hi;
      burst_act = act & brst;
      cur_steal = (cur == OWN_CH0 && !brst[0]) || (cur == OWN_CH1 && !brst[1]);
      if (act == 2'b00) begin
         nxt = OWN_CPU;
      end else if (brst[cand]) begin
         nxt = cand ? OWN_CH1 : OWN_CH0;
      end else if (cur_steal) begin
         if (burst_act[0])      nxt = OWN_CH0;
         else if (burst_act[1]) nxt = OWN_CH1;
         else                   nxt = OWN_CPU;
      end else begin
         nxt = cand ? OWN_CH1 : OWN_CH0;
      end
   end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter bit RR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ch_req,
   input  logic [1:0]       ch_burst,
   input  logic [CNT_W-1:0] ch0_len,
   input  logic [CNT_W-1:0] ch1_len,
   input  logic             prio_rr,
   input  logic             xfer_done,
   output logic [2:0]       gnt,
   output logic [1:0]       owner,
   output logic             cfg_err,
   output logic [CNT_W-1:0] ch0_left,
   output logic [CNT_W-1:0] ch1_left
);
   localparam int NCH = 2;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
      $error("dma_bus_arbiter: CNT_W must be 1..16");
   end

   logic             rr_mode;
   if (RR_EN) begin : g_rr
      assign rr_mode = prio_rr;
   end else begin : g_fixed
      assign rr_mode = prio_rr & 1'b0;
   end

   own_e             own_q, own_nx;
   logic             rr_pri;
   logic [CNT_W-1:0] len_a [NCH];
   logic [CNT_W-1:0] rem_a [NCH];
   logic [NCH-1:0]   act, brst, act_nx, brst_nx, try, rej, load, dec;

   assign len_a[0] = ch0_len;
   assign len_a[1] = ch1_len;

   assign try    = ch_req & ~act & {(ch1_len != '0), (ch0_len != '0)};
   assign rej[0] = rr_mode & try[0] & act[1] & (brst[1] != ch_burst[0]);
   assign rej[1] = rr_mode & try[1] &
                   ((act[0] & (brst[0] != ch_burst[1])) |
                    (try[0] & ~rej[0] & (ch_burst[0] != ch_burst[1])));
   assign load   = try & ~rej;
   assign dec[0] = xfer_done & (own_q == OWN_CH0);
   assign dec[1] = xfer_done & (own_q == OWN_CH1);

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      dma_chan_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load[k]),
         .len        (len_a[k]),
         .mode_burst (ch_burst[k]),
         .dec        (dec[k]),
         .remain     (rem_a[k]),
         .burst_q    (brst[k]),
         .active     (act[k]),
         .nxt_active (act_nx[k]),
         .nxt_burst  (brst_nx[k])
      );
   end

   dma_slot_pick u_pick (
      .act     (act_nx),
      .brst    (brst_nx),
      .rr_mode (rr_mode),
      .rr_pri  (rr_pri),
      .cur     (own_q),
      .nxt     (own_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q   <= OWN_CPU;
         rr_pri  <= 1'b0;
         cfg_err <= 1'b0;
      end else begin
         cfg_err <= |rej;
         if (xfer_done) begin
            own_q <= own_nx;
            if (own_nx == OWN_CH0)      rr_pri <= 1'b1;
            else if (own_nx == OWN_CH1) rr_pri <= 1'b0;
         end
      end
   end

   assign owner    = own_q;
   assign gnt      = {own_q == OWN_CH1, own_q == OWN_CH0, own_q == OWN_CPU};
   assign ch0_left = rem_a[0];
   assign ch1_left = rem_a[1];

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt) == 1); // R2
   AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_done |=> $stable(owner)); // R3
   AST_CPU_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && ch0_left == '0 && ch1_left == '0 && ch_req == 2'b00)
      |=> (owner == OWN_CPU)); // R5
   AST_OWNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_CH0 |-> ch0_left != '0) and
      (owner == OWN_CH1 |-> ch1_left != '0)); // R9
   AST_RR_NOMIX: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_mode && act == 2'b11) |-> (brst[0] == brst[1])); // R11
endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [1:0]       ch_req, ch_burst;
   logic [CNT_W-1:0] ch0_len, ch1_len;
   logic             prio_rr, xfer_done;
   logic [2:0]       gnt;
   logic [1:0]       owner;
   logic             cfg_err;
   logic [CNT_W-1:0] ch0_left, ch1_left;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dma_bus_arbiter #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_burst(ch_burst),
      .ch0_len(ch0_len), .ch1_len(ch1_len), .prio_rr(prio_rr),
      .xfer_done(xfer_done), .gnt(gnt), .owner(owner), .cfg_err(cfg_err),
      .ch0_left(ch0_left), .ch1_left(ch1_left)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_owner(input string tag, input int exp);
      chk(tag, owner, exp);
      chk({tag, " R2 gnt"}, gnt, 1 << exp);
   endtask

   task automatic do_reset(input logic rr);
      @(negedge clk);
      rst_n = 1'b0; ch_req = '0; ch_burst = '0; ch0_len = '0; ch1_len = '0;
      xfer_done = 1'b0; prio_rr = rr;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic start(input logic [1:0] req, input logic [1:0] md,
                        input int l0, input int l1);
      ch_req = req; ch_burst = md; ch0_len = CNT_W'(l0); ch1_len = CNT_W'(l1);
      @(negedge clk);
      ch_req = '0;
   endtask

   task automatic slot(input string tag, input int exp);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk_owner(tag, exp);
   endtask

   initial begin
      do_reset(1'b0);
      chk_owner("R1 reset owner", 0);
      chk("R1 reset ch0_left", ch0_left, 0);
      chk("R1 reset ch1_left", ch1_left, 0);
      chk("R1 reset cfg_err", cfg_err, 0);

      // Fixed priority, both burst: ch1 runs, ch0 preempts
      start(2'b10, 2'b11, 0, 3);
      chk("R4 ch1 loaded", ch1_left, 3);
      repeat (3) @(negedge clk);
      chk_owner("R3 owner held without strobe", 0);
      slot("R9 ch1 burst slot1", 2);
      slot("R9 ch1 burst slot2", 2);
      start(2'b11, 2'b11, 2, 7);
      chk("R4 busy ch1 re-request ignored", ch1_left, 2);
      slot("R6 ch0 preempts ch1", 1);
      chk("R4 ch1 decremented", ch1_left, 1);
      slot("R6 ch0 continues", 1);
      chk("R4 ch0 decremented", ch0_left, 1);
      slot("R6 ch1 resumes after ch0", 2);
      slot("R5 cpu after all done", 0);
      chk("R4 ch1 drained", ch1_left, 0);
      slot("R5 cpu stays owner", 0);

      // Fixed: ch0 cycle-steal, ch1 burst interleave
      do_reset(1'b0);
      start(2'b11, 2'b10, 2, 3);
      slot("R7 interleave 1 ch0", 1);
      slot("R7 interleave 2 ch1", 2);
      slot("R7 interleave 3 ch0", 1);
      slot("R7 interleave 4 ch1", 2);
      slot("R9 ch1 finishes burst", 2);
      slot("R5 cpu after interleave", 0);

      // Lone cycle-steal channel
      do_reset(1'b0);
      start(2'b10, 2'b00, 0, 2);
      slot("R8 steal unit 1", 2);
      slot("R8 cpu gap", 0);
      slot("R8 steal unit 2", 2);
      slot("R8 cpu after last", 0);
      slot("R5 cpu idle", 0);

      // Round-robin, both burst
      do_reset(1'b1);
      start(2'b11, 2'b11, 2, 2);
      slot("R10 rr ch0 first", 1);
      slot("R10 rr ch1 next", 2);
      slot("R10 rr ch0 again", 1);
      slot("R10 rr ch1 again", 2);
      slot("R10 rr cpu at end", 0);

      // Round-robin mixed mode refusal
      do_reset(1'b1);
      start(2'b01, 2'b01, 2, 0);
      chk("R11 no error on clean start", cfg_err, 0);
      ch_req = 2'b10; ch_burst = 2'b00; ch1_len = CNT_W'(1);
      @(negedge clk);
      ch_req = '0;
      chk("R11 cfg_err pulse", cfg_err, 1);
      chk("R11 refused ch1 count", ch1_left, 0);
      @(negedge clk);
      chk("R11 cfg_err clears", cfg_err, 0);
      slot("R11 ch0 owns", 1);
      slot("R11 ch0 continues", 1);
      slot("R11 cpu after", 0);

      // Round-robin simultaneous mixed start: ch1 refused
      do_reset(1'b1);
      ch_req = 2'b11; ch_burst = 2'b10; ch0_len = CNT_W'(1); ch1_len = CNT_W'(1);
      @(negedge clk);
      ch_req = '0;
      chk("R11 same-cycle err", cfg_err, 1);
      chk("R11 same-cycle ch0 kept", ch0_left, 1);
      chk("R11 same-cycle ch1 refused", ch1_left, 0);
      slot("R8 rr lone steal", 1);
      slot("R8 rr cpu after steal", 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule